// File: doc/BRIEF.md
# Triggered Command-Set Sequencer

This block holds a few independent command sets behind a plain register port. Each set has room for up to sixteen command slots. A slot holds three words: a message identifier, a target address and a data word. Software fills the slots it needs and marks them in the set's enable bitmap. It then arms the set with the mode-enable bit of the set's control register and fires it with the trigger bit. The sequencer then drives the enabled slots, lowest index first, onto a valid/ready command stream.

A slot whose message identifier asks for a response holds the stream until the downstream side pulses `rsp_valid_i`. The response word is stored in that slot. Slots that ask for no response are complete at their handshake and may follow one another on consecutive cycles. The stream follows the usual rules for back-pressure. Once `cmd_valid_o` is high, it and the payload (`cmd_set_o`, `cmd_msgid_o`, `cmd_addr_o`, `cmd_data_o`) stay unchanged until the cycle in which `cmd_ready_i` is high. The sink may hold `cmd_ready_i` low for as long as it likes.

Each slot records whether it was issued and whether it completed. Each set posts a bit in a shared interrupt status register when it finishes. Software clears that bit by writing a one to it. The interrupt line is the OR of the status bits that are unmasked. Only one command is in flight at a time. When several sets are waiting, the lowest-numbered set is served first.

Top module: `cmdseq_top`

## Requirements
- R1: After reset every control, enable, slot status and interrupt register reads zero and `cmd_valid_o` is low. The configuration word at 0x0C reads the slot count in bits 31:27 and the set count in bits 5:0.
- R2: Set k occupies 672 bytes starting at SET_BASE + 672*k. Within a set, control is at 0x14, status at 0x18 (bit 0 = busy) and the slot-enable bitmap at 0x1C. Slot n has its message identifier at 0x30+20n, its address at +4, its data at +8, its status at +0x0C and its response word at +0x10. The message, address and data words read back as written. Control bits 16 and 24 read back as written and all other control bits read zero.
- R3: A set fires only on a control write that sets the trigger (bit 24) while the trigger was clear, the mode enable (bit 16) was already set, and the write keeps bit 16 set. A single write that sets both bits from zero does not fire.
- R4: A fired set emits only the slots whose enable bit is set, in ascending slot order, with the stored message, address and data words and its own index on `cmd_set_o`.
- R5: While `cmd_valid_o` is high and `cmd_ready_i` is low, the valid signal and the payload stay unchanged.
- R6: After the handshake of a slot whose message identifier has bit 8 set, no command is sent until `rsp_valid_i`, and `rsp_data_i` is stored in that slot's response word. A slot with bit 8 clear is followed on the very next cycle by the next enabled slot.
- R7: A slot's status has bit 8 (issued) set at its handshake. It has bit 16 (completed) set at the handshake when no response is asked for, or at `rsp_valid_i` otherwise. All slot status bits of a set clear when that set fires.
- R8: Bit k of the interrupt status at 0x04 rises when set k finishes. This happens only when every enabled slot of the set shows completed, and in the same cycle the set's busy bit clears. A set fired with an empty bitmap finishes without emitting anything.
- R9: Writing a one to bit k at 0x08 clears interrupt status bit k. The mask at 0x00 gates the status bits onto `irq_o`.
- R10: A trigger written while the set is busy does not start a second run.
- R11: Writing zero to the enable bitmap of a busy set cancels its remaining slots. The command in flight still finishes, then the set finishes. A nonzero write to the bitmap of a busy set is ignored.
- R12: When several sets are busy and the engine is free, the lowest-numbered busy set is served to completion before any other set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational from address) |
| cmd_valid_o | output | 1 | Command stream valid |
| cmd_ready_i | input | 1 | Command stream ready |
| cmd_set_o | output | SET_IW | Index of the set being sent |
| cmd_msgid_o | output | 32 | Message identifier of the slot |
| cmd_addr_o | output | 32 | Target address of the slot |
| cmd_data_o | output | 32 | Data word of the slot |
| rsp_valid_i | input | 1 | Response strobe for the waiting slot |
| rsp_data_i | input | 32 | Response word |
| irq_o | output | 1 | OR of unmasked completion bits |

## Verification
The hardest situations to reach are those where register writes land while a set is running: a cancel, a repeated trigger, and a second and third set fired behind a running one. The bench's responder makes these reachable. It delays the response of a response-requesting slot by a chosen number of cycles, which holds the engine in its wait state for a known window. The bench waits for the first handshake in its log and issues the disruptive writes inside that window. It then checks the logged command order and the readable status against the expected outcome.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;
  localparam int unsigned WORD_W      = 32;
  localparam int unsigned LOC_W       = 10;
  localparam int unsigned SET_STRIDE  = 672;
  localparam int unsigned SLOT_STRIDE = 20;
  localparam int unsigned OFF_IRQ_EN  = 'h00;
  localparam int unsigned OFF_IRQ_ST  = 'h04;
  localparam int unsigned OFF_IRQ_CLR = 'h08;
  localparam int unsigned OFF_CFG     = 'h0C;
  localparam int unsigned OFF_CTRL    = 'h14;
  localparam int unsigned OFF_STAT    = 'h18;
  localparam int unsigned OFF_CMDEN   = 'h1C;
  localparam int unsigned OFF_SLOT0   = 'h30;
  localparam int unsigned FLD_MSG     = 'h00;
  localparam int unsigned FLD_ADDR    = 'h04;
  localparam int unsigned FLD_DATA    = 'h08;
  localparam int unsigned FLD_STAT    = 'h0C;
  localparam int unsigned FLD_RESP    = 'h10;
  localparam int unsigned CTRL_ARM_BIT  = 16;
  localparam int unsigned CTRL_FIRE_BIT = 24;
  localparam int unsigned MSG_RSP_BIT   = 8;
  localparam int unsigned ST_ISS_BIT    = 8;
  localparam int unsigned ST_CMPL_BIT   = 16;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_SCAN,
    ENG_SEND,
    ENG_WAIT
  } eng_state_e;
endpackage

// File: rtl/cmdseq_set.sv
module cmdseq_set
  import cmdseq_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 16,
  localparam int unsigned SLOT_IW  = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_i,
  input  logic [LOC_W-1:0]      loc_i,
  input  logic [WORD_W-1:0]     wdata_i,
  output logic [WORD_W-1:0]     rdata_o,
  output logic                  busy_o,
  output logic [NUM_SLOTS-1:0]  en_mask_o,
  output logic [NUM_SLOTS-1:0]  done_mask_o,
  input  logic [SLOT_IW-1:0]    slot_sel_i,
  output logic [WORD_W-1:0]     sel_msgid_o,
  output logic [WORD_W-1:0]     sel_addr_o,
  output logic [WORD_W-1:0]     sel_data_o,
  input  logic                  ev_issue_i,
  input  logic                  ev_cmpl_i,
  input  logic                  ev_rsp_we_i,
  input  logic [WORD_W-1:0]     ev_rsp_data_i,
  input  logic                  finish_i
);
  localparam logic [LOC_W-1:0] A_CTRL  = LOC_W'(OFF_CTRL);
  localparam logic [LOC_W-1:0] A_STAT  = LOC_W'(OFF_STAT);
  localparam logic [LOC_W-1:0] A_CMDEN = LOC_W'(OFF_CMDEN);

  logic                 arm_q, fire_q, busy_q;
  logic [NUM_SLOTS-1:0] en_q, iss_q, cmpl_q;
  logic [WORD_W-1:0]    msg_q  [NUM_SLOTS];
  logic [WORD_W-1:0]    addr_q [NUM_SLOTS];
  logic [WORD_W-1:0]    data_q [NUM_SLOTS];
  logic [WORD_W-1:0]    resp_q [NUM_SLOTS];

  logic wr_ctrl, wr_en, start;
  assign wr_ctrl = wr_i && (loc_i == A_CTRL);
  assign wr_en   = wr_i && (loc_i == A_CMDEN);
  assign start   = wr_ctrl && wdata_i[CTRL_FIRE_BIT] && wdata_i[CTRL_ARM_BIT]
                   && !fire_q && arm_q && !busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q  <= 1'b0;
      fire_q <= 1'b0;
      busy_q <= 1'b0;
      en_q   <= '0;
    end else begin
      if (wr_ctrl) begin
        arm_q  <= wdata_i[CTRL_ARM_BIT];
        fire_q <= wdata_i[CTRL_FIRE_BIT];
      end
      if (start)         busy_q <= 1'b1;
      else if (finish_i) busy_q <= 1'b0;
      if (wr_en) begin
        if (!busy_q)                               en_q <= wdata_i[NUM_SLOTS-1:0];
        else if (wdata_i[NUM_SLOTS-1:0] == '0)     en_q <= '0;
      end
    end
  end

  for (genvar j = 0; j < NUM_SLOTS; j++) begin : g_slot
    localparam int unsigned SB = OFF_SLOT0 + j * SLOT_STRIDE;
    localparam logic [LOC_W-1:0] A_MSG  = LOC_W'(SB + FLD_MSG);
    localparam logic [LOC_W-1:0] A_ADDR = LOC_W'(SB + FLD_ADDR);
    localparam logic [LOC_W-1:0] A_DATA = LOC_W'(SB + FLD_DATA);
    logic here;
    assign here = (slot_sel_i == SLOT_IW'(j));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        msg_q[j]  <= '0;
        addr_q[j] <= '0;
        data_q[j] <= '0;
        resp_q[j] <= '0;
        iss_q[j]  <= 1'b0;
        cmpl_q[j] <= 1'b0;
      end else begin
        if (wr_i && loc_i == A_MSG)  msg_q[j]  <= wdata_i;
        if (wr_i && loc_i == A_ADDR) addr_q[j] <= wdata_i;
        if (wr_i && loc_i == A_DATA) data_q[j] <= wdata_i;
        if (ev_rsp_we_i && here)     resp_q[j] <= ev_rsp_data_i;
        if (start) begin
          iss_q[j]  <= 1'b0;
          cmpl_q[j] <= 1'b0;
        end else begin
          if (ev_issue_i && here) iss_q[j]  <= 1'b1;
          if (ev_cmpl_i && here)  cmpl_q[j] <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (loc_i == A_CTRL) begin
      rdata_o[CTRL_ARM_BIT]  = arm_q;
      rdata_o[CTRL_FIRE_BIT] = fire_q;
    end
    if (loc_i == A_STAT)  rdata_o[0] = busy_q;
    if (loc_i == A_CMDEN) rdata_o[NUM_SLOTS-1:0] = en_q;
    for (int j = 0; j < NUM_SLOTS; j++) begin
      if (loc_i == LOC_W'(OFF_SLOT0 + j * SLOT_STRIDE + FLD_MSG))  rdata_o = msg_q[j];
      if (loc_i == LOC_W'(OFF_SLOT0 + j * SLOT_STRIDE + FLD_ADDR)) rdata_o = addr_q[j];
      if (loc_i == LOC_W'(OFF_SLOT0 + j * SLOT_STRIDE + FLD_DATA)) rdata_o = data_q[j];
      if (loc_i == LOC_W'(OFF_SLOT0 + j * SLOT_STRIDE + FLD_RESP)) rdata_o = resp_q[j];
      if (loc_i == LOC_W'(OFF_SLOT0 + j * SLOT_STRIDE + FLD_STAT)) begin
        rdata_o = '0;
        rdata_o[ST_ISS_BIT]  = iss_q[j];
        rdata_o[ST_CMPL_BIT] = cmpl_q[j];
      end
    end
  end

  assign busy_o      = busy_q;
  assign en_mask_o   = en_q;
  assign done_mask_o = cmpl_q;
  assign sel_msgid_o = msg_q[slot_sel_i];
  assign sel_addr_o  = addr_q[slot_sel_i];
  assign sel_data_o  = data_q[slot_sel_i];
endmodule

// File: rtl/cmdseq_engine.sv
module cmdseq_engine
  import cmdseq_pkg::*;
#(
  parameter int unsigned NUM_SETS  = 4,
  parameter int unsigned NUM_SLOTS = 16,
  localparam int unsigned SET_IW   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
  localparam int unsigned SLOT_IW  = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SETS-1:0]  busy_i,
  input  logic [NUM_SLOTS-1:0] en_mask_i,
  input  logic                 want_rsp_i,
  input  logic                 cmd_ready_i,
  input  logic                 rsp_valid_i,
  output logic [SET_IW-1:0]    sel_set_o,
  output logic [SLOT_IW-1:0]   slot_o,
  output logic                 cmd_valid_o,
  output logic                 issue_o,
  output logic                 cmpl_o,
  output logic                 rsp_we_o,
  output logic                 finish_o
);
  eng_state_e         st_q;
  logic [SET_IW-1:0]  set_q;
  logic [SLOT_IW-1:0] cur_q;

  logic [SLOT_IW:0]   from;
  logic               nxt_found;
  logic [SLOT_IW-1:0] nxt_idx;
  logic               low_found;
  logic [SET_IW-1:0]  low_idx;
  logic               hs, got_rsp, advance;

  assign from = (st_q == ENG_SCAN) ? '0 : ({1'b0, cur_q} + {{SLOT_IW{1'b0}}, 1'b1});

  always_comb begin
    nxt_found = 1'b0;
    nxt_idx   = '0;
    for (int j = NUM_SLOTS - 1; j >= 0; j--) begin
      if (en_mask_i[j] && ((SLOT_IW+1)'(j) >= from)) begin
        nxt_found = 1'b1;
        nxt_idx   = SLOT_IW'(j);
      end
    end
  end

  always_comb begin
    low_found = 1'b0;
    low_idx   = '0;
    for (int k = NUM_SETS - 1; k >= 0; k--) begin
      if (busy_i[k]) begin
        low_found = 1'b1;
        low_idx   = SET_IW'(k);
      end
    end
  end

  assign cmd_valid_o = (st_q == ENG_SEND);
  assign hs          = cmd_valid_o && cmd_ready_i;
  assign got_rsp     = (st_q == ENG_WAIT) && rsp_valid_i;
  assign issue_o     = hs;
  assign cmpl_o      = (hs && !want_rsp_i) || got_rsp;
  assign rsp_we_o    = got_rsp;
  assign advance     = cmpl_o || (st_q == ENG_SCAN);
  assign finish_o    = advance && !nxt_found;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ENG_IDLE;
      set_q <= '0;
      cur_q <= '0;
    end else begin
      case (st_q)
        ENG_IDLE: if (low_found) begin
          set_q <= low_idx;
          st_q  <= ENG_SCAN;
        end
        ENG_SEND: if (hs && want_rsp_i) st_q <= ENG_WAIT;
        default: ;
      endcase
      if (advance) begin
        if (nxt_found) begin
          cur_q <= nxt_idx;
          st_q  <= ENG_SEND;
        end else begin
          st_q <= ENG_IDLE;
        end
      end
    end
  end

  assign sel_set_o = set_q;
  assign slot_o    = cur_q;
endmodule

// File: rtl/cmdseq_top.sv
module cmdseq_top
  import cmdseq_pkg::*;
#(
  parameter int unsigned NUM_SETS  = 4,
  parameter int unsigned NUM_SLOTS = 16,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned SET_BASE  = 256,
  localparam int unsigned SET_IW   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
  localparam int unsigned SLOT_IW  = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [SET_IW-1:0] cmd_set_o,
  output logic [31:0]       cmd_msgid_o,
  output logic [31:0]       cmd_addr_o,
  output logic [31:0]       cmd_data_o,
  input  logic              rsp_valid_i,
  input  logic [31:0]       rsp_data_i,
  output logic              irq_o
);
  logic [NUM_SETS-1:0]  irq_en_q, irq_stat_q, busy_vec, set_hit;
  logic [WORD_W-1:0]    set_rdata [NUM_SETS];
  logic [WORD_W-1:0]    set_msgid [NUM_SETS];
  logic [WORD_W-1:0]    set_addr  [NUM_SETS];
  logic [WORD_W-1:0]    set_data  [NUM_SETS];
  logic [NUM_SLOTS-1:0] set_en    [NUM_SETS];
  logic [NUM_SETS*NUM_SLOTS-1:0] en_flat, done_flat;

  logic [SET_IW-1:0]  sel_set;
  logic [SLOT_IW-1:0] cur_slot;
  logic ev_issue, ev_cmpl, ev_rsp_we, ev_finish;
  logic glob_hit;

  assign glob_hit = (reg_addr_i < ADDR_W'(SET_BASE));

  for (genvar k = 0; k < NUM_SETS; k++) begin : g_set
    localparam int unsigned B = SET_BASE + k * SET_STRIDE;
    logic mine;
    logic [LOC_W-1:0] loc;
    assign set_hit[k] = (reg_addr_i >= ADDR_W'(B)) && (reg_addr_i < ADDR_W'(B + SET_STRIDE));
    assign loc        = LOC_W'(reg_addr_i - ADDR_W'(B));
    assign mine       = (sel_set == SET_IW'(k));

    cmdseq_set #(.NUM_SLOTS(NUM_SLOTS)) u_set (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_i         (reg_we_i && set_hit[k]),
      .loc_i        (loc),
      .wdata_i      (reg_wdata_i),
      .rdata_o      (set_rdata[k]),
      .busy_o       (busy_vec[k]),
      .en_mask_o    (set_en[k]),
      .done_mask_o  (done_flat[k*NUM_SLOTS +: NUM_SLOTS]),
      .slot_sel_i   (cur_slot),
      .sel_msgid_o  (set_msgid[k]),
      .sel_addr_o   (set_addr[k]),
      .sel_data_o   (set_data[k]),
      .ev_issue_i   (ev_issue && mine),
      .ev_cmpl_i    (ev_cmpl && mine),
      .ev_rsp_we_i  (ev_rsp_we && mine),
      .ev_rsp_data_i(rsp_data_i),
      .finish_i     (ev_finish && mine)
    );
    assign en_flat[k*NUM_SLOTS +: NUM_SLOTS] = set_en[k];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        irq_en_q[k]   <= 1'b0;
        irq_stat_q[k] <= 1'b0;
      end else begin
        if (reg_we_i && reg_addr_i == ADDR_W'(OFF_IRQ_EN)) irq_en_q[k] <= reg_wdata_i[k];
        if (ev_finish && mine) irq_stat_q[k] <= 1'b1;
        else if (reg_we_i && reg_addr_i == ADDR_W'(OFF_IRQ_CLR) && reg_wdata_i[k])
          irq_stat_q[k] <= 1'b0;
      end
    end
  end

  cmdseq_engine #(.NUM_SETS(NUM_SETS), .NUM_SLOTS(NUM_SLOTS)) u_eng (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy_i      (busy_vec),
    .en_mask_i   (set_en[sel_set]),
    .want_rsp_i  (set_msgid[sel_set][MSG_RSP_BIT]),
    .cmd_ready_i (cmd_ready_i),
    .rsp_valid_i (rsp_valid_i),
    .sel_set_o   (sel_set),
    .slot_o      (cur_slot),
    .cmd_valid_o (cmd_valid_o),
    .issue_o     (ev_issue),
    .cmpl_o      (ev_cmpl),
    .rsp_we_o    (ev_rsp_we),
    .finish_o    (ev_finish)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (glob_hit) begin
      if (reg_addr_i == ADDR_W'(OFF_IRQ_EN)) reg_rdata_o[NUM_SETS-1:0] = irq_en_q;
      if (reg_addr_i == ADDR_W'(OFF_IRQ_ST)) reg_rdata_o[NUM_SETS-1:0] = irq_stat_q;
      if (reg_addr_i == ADDR_W'(OFF_CFG)) begin
        reg_rdata_o[31:27] = 5'(NUM_SLOTS);
        reg_rdata_o[5:0]   = 6'(NUM_SETS);
      end
    end
    for (int k = 0; k < NUM_SETS; k++) begin
      if (set_hit[k]) reg_rdata_o = set_rdata[k];
    end
  end

  assign cmd_set_o   = sel_set;
  assign cmd_msgid_o = set_msgid[sel_set];
  assign cmd_addr_o  = set_addr[sel_set];
  assign cmd_data_o  = set_data[sel_set];
  assign irq_o       = |(irq_stat_q & irq_en_q);
endmodule

// File: rtl/cmdseq_sva.sv
module cmdseq_sva #(
  parameter int unsigned NUM_SETS  = 4,
  parameter int unsigned NUM_SLOTS = 16,
  localparam int unsigned SET_IW   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          cmd_valid,
  input logic                          cmd_ready,
  input logic [SET_IW-1:0]             cmd_set,
  input logic [31:0]                   cmd_msgid,
  input logic [31:0]                   cmd_addr,
  input logic [31:0]                   cmd_data,
  input logic [NUM_SETS-1:0]           busy_vec,
  input logic [NUM_SETS-1:0]           irq_stat,
  input logic [NUM_SETS*NUM_SLOTS-1:0] en_flat,
  input logic [NUM_SETS*NUM_SLOTS-1:0] done_flat
);
  p_hold_payload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_msgid) && $stable(cmd_addr)
                                && $stable(cmd_data) && $stable(cmd_set));

  p_wait_for_rsp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_msgid[8] |=> !cmd_valid);

  p_sender_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> busy_vec[cmd_set]);

  for (genvar k = 0; k < NUM_SETS; k++) begin : g_chk
    p_done_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_stat[k]) |->
        ((en_flat[k*NUM_SLOTS +: NUM_SLOTS] & ~done_flat[k*NUM_SLOTS +: NUM_SLOTS]) == '0));

    p_done_from_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_stat[k]) |-> $past(busy_vec[k]) && !busy_vec[k]);
  end
endmodule

bind cmdseq_top cmdseq_sva #(.NUM_SETS(NUM_SETS), .NUM_SLOTS(NUM_SLOTS)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid_o),
  .cmd_ready (cmd_ready_i),
  .cmd_set   (cmd_set_o),
  .cmd_msgid (cmd_msgid_o),
  .cmd_addr  (cmd_addr_o),
  .cmd_data  (cmd_data_o),
  .busy_vec  (busy_vec),
  .irq_stat  (irq_stat_q),
  .en_flat   (en_flat),
  .done_flat (done_flat)
);

// File: tb/cmdseq_top_tb.sv
module cmdseq_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SETS = 4;
  localparam int SLOTS = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cmd_valid;
  logic        cmd_ready = 1'b0;
  logic [1:0]  cmd_set;
  logic [31:0] cmd_msgid, cmd_addr, cmd_data;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_data = '0;
  logic        irq;

  cmdseq_top dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .cmd_valid_o(cmd_valid),
    .cmd_ready_i(cmd_ready), .cmd_set_o(cmd_set), .cmd_msgid_o(cmd_msgid),
    .cmd_addr_o(cmd_addr), .cmd_data_o(cmd_data), .rsp_valid_i(rsp_valid),
    .rsp_data_i(rsp_data), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0;
  bit stall_en = 0;
  int rsp_delay = 0;
  bit pend = 0;
  int cnt = 0;
  logic [31:0] pend_addr = '0;
  int log_n = 0;
  logic [1:0]  log_set [64];
  logic [31:0] log_addr [64];
  logic [31:0] log_data [64];
  logic [31:0] log_msg [64];
  int          log_cyc [64];

  always @(negedge clk) begin
    rsp_valid = 1'b0;
    if (pend) begin
      if (cnt == 0) begin
        rsp_valid = 1'b1;
        rsp_data  = 32'hA500_0000 ^ pend_addr;
        pend      = 1'b0;
      end else cnt--;
    end
    cmd_ready = stall_en ? (cyc % 3 != 0) : 1'b1;
    #1;
    if (rst_n && cmd_valid && cmd_ready && log_n < 64) begin
      log_set[log_n]  = cmd_set;
      log_addr[log_n] = cmd_addr;
      log_data[log_n] = cmd_data;
      log_msg[log_n]  = cmd_msgid;
      log_cyc[log_n]  = cyc;
      log_n++;
      if (cmd_msgid[8]) begin
        pend = 1'b1; cnt = rsp_delay; pend_addr = cmd_addr;
      end
    end
  end

  function automatic logic [11:0] sb(int k);
    return 12'(256 + 672 * k);
  endfunction
  function automatic logic [11:0] sl(int k, int n, int f);
    return 12'(256 + 672 * k + 48 + 20 * n + f);
  endfunction
  function automatic logic [31:0] mk_msg(bit rsp);
    return 32'h0001_0008 | (32'(rsp) << 8);
  endfunction
  function automatic logic [31:0] mk_addr(int k, int n);
    return 32'h0003_0000 + 32'(n * 16 + k);
  endfunction
  function automatic logic [31:0] mk_data(int k, int n);
    return 32'hD000_0000 | 32'(k << 8) | 32'(n);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #2 d = reg_rdata;
  endtask

  task automatic prog(int k, int n, bit rsp);
    wr(sl(k, n, 0), mk_msg(rsp));
    wr(sl(k, n, 4), mk_addr(k, n));
    wr(sl(k, n, 8), mk_data(k, n));
  endtask

  task automatic fire(int k);
    wr(sb(k) + 12'h14, 32'h0001_0000);
    wr(sb(k) + 12'h14, 32'h0000_0000);
    wr(sb(k) + 12'h14, 32'h0001_0000);
    wr(sb(k) + 12'h14, 32'h0101_0000);
  endtask

  task automatic wait_irq(int k);
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd(12'h004, v);
      if (v[k]) return;
    end
    chk("R8 timeout", 32'(k), 32'hFFFF_FFFF);
  endtask

  task automatic wait_log(int n);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); #2;
      if (log_n >= n) return;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 cmd_valid", 32'(cmd_valid), 0);
    rd(12'h004, v); chk("R1 irq status", v, 0);
    rd(12'h000, v); chk("R1 irq mask", v, 0);
    rd(12'h00C, v); chk("R1 config", v, 32'h8000_0004);
    rd(sb(0) + 12'h14, v); chk("R1 ctrl", v, 0);
    rd(sb(3) + 12'h1C, v); chk("R1 enable", v, 0);
    rd(sl(2, 5, 12), v); chk("R1 slot status", v, 0);
  endtask

  task automatic t_regmap();
    logic [31:0] v;
    wr(sl(2, 15, 0), 32'h1234_5678); rd(sl(2, 15, 0), v); chk("R2 msg rb", v, 32'h1234_5678);
    wr(sl(1, 0, 4), 32'hCAFE_0001);  rd(sl(1, 0, 4), v);  chk("R2 addr rb", v, 32'hCAFE_0001);
    wr(sl(3, 7, 8), 32'h0BAD_F00D);  rd(sl(3, 7, 8), v);  chk("R2 data rb", v, 32'h0BAD_F00D);
    rd(sl(2, 14, 0), v); chk("R2 neighbour untouched", v, 0);
    wr(sb(1) + 12'h1C, 32'h0000_0001);
    wr(sb(1) + 12'h14, 32'hFFFF_FFFF);
    rd(sb(1) + 12'h14, v); chk("R2 ctrl rb", v, 32'h0101_0000);
    repeat (4) @(negedge clk);
    rd(sb(1) + 12'h18, v); chk("R3 no start from zero", v, 0);
    chk("R3 nothing sent", 32'(log_n), 0);
    wr(sb(1) + 12'h14, 0);
    wr(sb(1) + 12'h1C, 0);
  endtask

  task automatic t_basic();
    logic [31:0] v;
    log_n = 0; stall_en = 0;
    wr(12'h000, 32'h1);
    prog(0, 0, 0); prog(0, 3, 0); prog(0, 7, 0); prog(0, 5, 0);
    wr(sb(0) + 12'h1C, 32'h0000_0089);
    fire(0);
    wait_irq(0);
    chk("R4 count", 32'(log_n), 3);
    chk("R4 first addr", log_addr[0], mk_addr(0, 0));
    chk("R4 second addr", log_addr[1], mk_addr(0, 3));
    chk("R4 third data", log_data[2], mk_data(0, 7));
    chk("R4 msg", log_msg[1], mk_msg(0));
    chk("R4 set index", 32'(log_set[2]), 0);
    chk("R6 back to back", 32'(log_cyc[2] - log_cyc[0]), 2);
    rd(sl(0, 3, 12), v); chk("R7 status enabled", v, 32'h0001_0100);
    rd(sl(0, 5, 12), v); chk("R7 status skipped", v, 0);
    rd(sb(0) + 12'h18, v); chk("R8 busy cleared", v, 0);
    @(negedge clk); #2 chk("R9 irq asserted", 32'(irq), 1);
    wr(12'h008, 32'h1);
    rd(12'h004, v); chk("R9 w1c", v, 0);
    #1 chk("R9 irq dropped", 32'(irq), 0);
  endtask

  task automatic t_resp();
    logic [31:0] v;
    log_n = 0; stall_en = 1; rsp_delay = 3;
    prog(1, 2, 1); prog(1, 5, 1); prog(1, 9, 0);
    wr(sb(1) + 12'h1C, 32'h0000_0224);
    fire(1);
    wait_irq(1);
    stall_en = 0;
    chk("R4 resp count", 32'(log_n), 3);
    chk("R5 order under stall", log_addr[1], mk_addr(1, 5));
    chk("R5 data under stall", log_data[2], mk_data(1, 9));
    chk("R6 gap held", 32'((log_cyc[1] - log_cyc[0]) >= 5), 1);
    rd(sl(1, 2, 16), v); chk("R6 response stored", v, 32'hA500_0000 ^ mk_addr(1, 2));
    rd(sl(1, 5, 12), v); chk("R7 resp slot done", v, 32'h0001_0100);
    #1 chk("R9 masked irq", 32'(irq), 0);
    wr(12'h008, 32'h2);
  endtask

  task automatic t_busy_trig();
    logic [31:0] v;
    log_n = 0; rsp_delay = 30;
    prog(3, 4, 1);
    wr(sb(3) + 12'h1C, 32'h0000_0010);
    fire(3);
    wait_log(1);
    fire(3);
    wr(sb(3) + 12'h1C, 32'h0000_FFFF);
    rd(sb(3) + 12'h1C, v); chk("R11 nonzero write ignored", v, 32'h10);
    rd(sb(3) + 12'h14, v); chk("R2 ctrl rb busy", v, 32'h0101_0000);
    wait_irq(3);
    repeat (6) @(negedge clk);
    chk("R10 single run", 32'(log_n), 1);
    wr(12'h008, 32'h8);
  endtask

  task automatic t_cancel();
    logic [31:0] v;
    log_n = 0; rsp_delay = 12;
    for (int n = 0; n < 4; n++) prog(2, n, 1);
    wr(sb(2) + 12'h1C, 32'h0000_000F);
    fire(2);
    wait_log(1);
    wr(sb(2) + 12'h1C, 0);
    wait_irq(2);
    chk("R11 cancelled count", 32'(log_n), 1);
    rd(sb(2) + 12'h1C, v); chk("R11 bitmap cleared", v, 0);
    rd(sl(2, 0, 12), v); chk("R11 inflight done", v, 32'h0001_0100);
    rd(sl(2, 1, 12), v); chk("R7 unsent status", v, 0);
    wr(12'h008, 32'h4);
  endtask

  task automatic t_empty();
    logic [31:0] v;
    log_n = 0;
    wr(sb(0) + 12'h1C, 0);
    fire(0);
    wait_irq(0);
    chk("R8 empty set sends nothing", 32'(log_n), 0);
    rd(sl(0, 3, 12), v); chk("R7 cleared on fire", v, 0);
    wr(12'h008, 32'h1);
  endtask

  task automatic t_multi();
    log_n = 0; rsp_delay = 60;
    prog(3, 0, 1); prog(1, 4, 0); prog(2, 6, 0);
    wr(sb(3) + 12'h1C, 32'h1);
    wr(sb(1) + 12'h1C, 32'h10);
    wr(sb(2) + 12'h1C, 32'h40);
    fire(3);
    wait_log(1);
    fire(2);
    fire(1);
    wait_irq(3); wait_irq(1); wait_irq(2);
    chk("R12 count", 32'(log_n), 3);
    chk("R12 first", 32'(log_set[0]), 3);
    chk("R12 lowest next", 32'(log_set[1]), 1);
    chk("R12 last", 32'(log_set[2]), 2);
    chk("R12 slot of set2", log_addr[2], mk_addr(2, 6));
  endtask

  bit done_flag = 0;
  initial begin
    wait (cyc > 150000 || done_flag);
    if (!done_flag) begin
      n_bad++;
      $display("FAIL watchdog: actual=%0d expected=finish", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_basic();
    t_resp();
    t_busy_trig();
    t_cancel();
    t_empty();
    t_multi();
    done_flag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule